// File: doc/BRIEF.md
# Bang-bang clock generator digital loop filter

This block is the digital loop filter of a clock generator whose phase-frequency detector only reports early or late. It receives one direction decision every clock cycle. It moves a 24-bit integrating register by a programmable power-of-two step in that direction. It then adds a programmable proportional step to form the control word. The word is split three ways to steer the oscillator:
- The top six bits select a coarse frequency band.
- The next three bits drive a thermometer-coded fine DAC segment. Only one unit switches per code step, which keeps glitches small.
- The next three bits drive a binary-weighted fine segment.
- The lowest twelve bits are not applied directly. A first-order sigma-delta modulator turns them into an occasional extra least-significant binary step, so their average value still reaches the oscillator.

Both gain shifts are plain inputs, so software or a test harness can change them at any cycle while the loop runs.

Top module: `clkgen_dlf`

## Requirements
- R1: After synchronous reset the integrator and the control word hold mid-scale (0x800000), so `band_code` = 32, `therm_code` = 0, `bin_code` = 0, and the dither residue and carry are zero.
- R2: Each cycle the integrator moves by 2^`int_shift`: upward when `dir_up` = 1 and downward when `dir_up` = 0.
- R3: The control word equals the updated integrator moved by a further 2^`prop_shift` in the same direction. This proportional step is not stored in the integrator.
- R4: Both the integrator and the control word saturate at 0 and at 0xFFFFFF and never wrap around.
- R5: A shift input greater than 23 acts as a shift of 23.
- R6: `band_code` equals bits 23:18 of the control word.
- R7: `therm_code` has as many ones as the value of control-word bits 17:15, filled from bit 0 upward. One more code step raises exactly one more output.
- R8: A 12-bit dither accumulator adds the previous cycle's control-word bits 11:0 each cycle, and its carry-out is registered.
- R9: `bin_code` equals control-word bits 14:12 plus the registered dither carry, saturating at 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_up | input | 1 | Detector decision, 1 = raise frequency |
| int_shift | input | 5 | Integral step exponent |
| prop_shift | input | 5 | Proportional step exponent |
| band_code | output | 6 | Coarse band select |
| therm_code | output | 7 | Thermometer fine segment |
| bin_code | output | 3 | Binary fine segment with dither |

## Verification
Two events can fall in the same cycle: a dither carry-out, and a binary fine field that is already at its maximum of 7. The bench drives the word to full scale with large shifts and then holds it there. The low twelve bits are all ones, so the dither carries on almost every cycle while bits 14:12 stay at 7. The output must then read 7 and must not wrap to 0. Randomized decisions with random gains also cross this condition, as well as the integrator saturation at both rails. Each of these cycles is compared against a bench model.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
    localparam int ACC_W  = 24;
    localparam int BAND_W = 6;
    localparam int SEG_W  = 3;
    localparam int BIN_W  = 3;
    localparam int DTH_W  = ACC_W - BAND_W - SEG_W - BIN_W;
    localparam int SH_W   = 5;
    localparam int THM_N  = (1 << SEG_W) - 1;
    localparam int BIN_LO = DTH_W;
    localparam int SEG_LO = DTH_W + BIN_W;
    localparam int BAND_LO = SEG_LO + SEG_W;
    localparam logic [ACC_W-1:0] MID = ACC_W'(1) << (ACC_W - 1);
    localparam logic [ACC_W:0] FULL = {1'b0, {ACC_W{1'b1}}};

    typedef struct packed {
        logic [BAND_W-1:0] band;
        logic [SEG_W-1:0]  seg;
        logic [BIN_W-1:0]  bin;
        logic [DTH_W-1:0]  frac;
    } word_fields_t;

    function automatic logic [ACC_W-1:0] sat_move(
        input logic [ACC_W-1:0] v,
        input logic [SH_W-1:0]  sh,
        input logic             up
    );
        logic [SH_W-1:0] s;
        logic [ACC_W:0]  step;
        logic [ACC_W:0]  ext;
        s    = (sh > SH_W'(ACC_W - 1)) ? SH_W'(ACC_W - 1) : sh;
        step = (ACC_W + 1)'(1) << s;
        ext  = {1'b0, v};
        if (up) begin
            ext = ext + step;
            return (ext > FULL) ? FULL[ACC_W-1:0] : ext[ACC_W-1:0];
        end
        return (step > ext) ? '0 : (ext[ACC_W-1:0] - step[ACC_W-1:0]);
    endfunction
endpackage

// File: rtl/dlf_therm_dec.sv
module dlf_therm_dec
    import dlf_pkg::*;
(
    input  logic [SEG_W-1:0] seg,
    output logic [THM_N-1:0] therm
);
    for (genvar i = 0; i < THM_N; i++) begin : g_unit
        assign therm[i] = (seg > SEG_W'(i));
    end
endmodule

// File: rtl/dlf_dither.sv
module dlf_dither
    import dlf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DTH_W-1:0] frac,
    input  logic [BIN_W-1:0] bin_in,
    output logic [BIN_W-1:0] bin_out
);
    logic [DTH_W-1:0] resid_q;
    logic             carry_q;
    logic [DTH_W:0]   sum;
    logic [BIN_W:0]   bsum;

    assign sum = {1'b0, resid_q} + {1'b0, frac};

    always_ff @(posedge clk) begin
        if (rst) begin
            resid_q <= '0;
            carry_q <= 1'b0;
        end else begin
            resid_q <= sum[DTH_W-1:0];
            carry_q <= sum[DTH_W];
        end
    end

    always_comb begin
        bsum    = {1'b0, bin_in} + {{BIN_W{1'b0}}, carry_q};
        bin_out = bsum[BIN_W] ? {BIN_W{1'b1}} : bsum[BIN_W-1:0];
    end
endmodule

// File: rtl/dlf_integrator.sv
module dlf_integrator
    import dlf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_up,
    input  logic [SH_W-1:0]  int_shift,
    input  logic [SH_W-1:0]  prop_shift,
    output logic [ACC_W-1:0] acc_q,
    output logic [ACC_W-1:0] word_q
);
    logic [ACC_W-1:0] acc_d;
    logic [ACC_W-1:0] word_d;

    always_comb begin
        acc_d  = sat_move(acc_q, int_shift, dir_up);
        word_d = sat_move(acc_d, prop_shift, dir_up);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= MID;
            word_q <= MID;
        end else begin
            acc_q  <= acc_d;
            word_q <= word_d;
        end
    end
endmodule

// File: rtl/clkgen_dlf.sv
module clkgen_dlf
    import dlf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dir_up,
    input  logic [SH_W-1:0]   int_shift,
    input  logic [SH_W-1:0]   prop_shift,
    output logic [BAND_W-1:0] band_code,
    output logic [THM_N-1:0]  therm_code,
    output logic [BIN_W-1:0]  bin_code
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] word_q;
    word_fields_t     fld;

    dlf_integrator u_integ (
        .clk       (clk),
        .rst       (rst),
        .dir_up    (dir_up),
        .int_shift (int_shift),
        .prop_shift(prop_shift),
        .acc_q     (acc_q),
        .word_q    (word_q)
    );

    assign fld       = word_fields_t'(word_q);
    assign band_code = fld.band;

    dlf_therm_dec u_therm (
        .seg  (fld.seg),
        .therm(therm_code)
    );

    dlf_dither u_dith (
        .clk    (clk),
        .rst    (rst),
        .frac   (fld.frac),
        .bin_in (fld.bin),
        .bin_out(bin_code)
    );
endmodule

// File: rtl/dlf_checker.sv
module dlf_checker
    import dlf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             dir_up,
    input logic [ACC_W-1:0] acc_q,
    input logic [ACC_W-1:0] word_q,
    input logic [THM_N-1:0] therm_code,
    input logic [BIN_W-1:0] bin_code
);
    AST_THERM_FILL: assert property (@(posedge clk) disable iff (rst)
        ((therm_code & (therm_code + THM_N'(1))) == '0)); // R7
    AST_THERM_COUNT: assert property (@(posedge clk) disable iff (rst)
        ($countones(therm_code) == int'(word_q[SEG_LO +: SEG_W]))); // R7
    AST_BIN_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (bin_code >= word_q[BIN_LO +: BIN_W])); // R9
    AST_UP_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dir_up)) |-> (acc_q >= $past(acc_q))); // R4
    AST_DOWN_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(dir_up)) |-> (acc_q <= $past(acc_q))); // R4
    AST_PROP_SIDE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dir_up)) |-> (word_q >= acc_q)); // R3
endmodule

bind clkgen_dlf dlf_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .dir_up    (dir_up),
    .acc_q     (acc_q),
    .word_q    (word_q),
    .therm_code(therm_code),
    .bin_code  (bin_code)
);

// File: tb/clkgen_dlf_bench.sv
`timescale 1ns/1ps
module clkgen_dlf_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dir_up = 1'b0;
    logic [4:0] int_shift = '0;
    logic [4:0] prop_shift = '0;
    logic [5:0] band_code;
    logic [6:0] therm_code;
    logic [2:0] bin_code;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int m_acc, m_word, m_res, m_cry;

    always #10 clk = ~clk;

    clkgen_dlf u_clkgen_dlf (
        .clk(clk), .rst(rst), .dir_up(dir_up), .int_shift(int_shift),
        .prop_shift(prop_shift), .band_code(band_code),
        .therm_code(therm_code), .bin_code(bin_code)
    );

    function automatic int mv(int v, int sh, bit up);
        int s = (sh > 23) ? 23 : sh;
        int r = up ? v + (1 << s) : v - (1 << s);
        if (r < 0) r = 0;
        if (r > 24'hFFFFFF) r = 24'hFFFFFF;
        return r;
    endfunction

    function automatic int exp_therm(int w);
        return (1 << ((w >> 15) & 7)) - 1;
    endfunction

    function automatic int exp_bin(int w, int c);
        int b = ((w >> 12) & 7) + c;
        return (b > 7) ? 7 : b;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic compare_all(string tag);
        check({tag, " R6 band"}, int'(band_code), m_word >> 18);
        check({tag, " R7 therm"}, int'(therm_code), exp_therm(m_word));
        check({tag, " R9 bin"}, int'(bin_code), exp_bin(m_word, m_cry));
    endtask

    task automatic step(bit up, int ki, int kp, string tag);
        int s;
        dir_up     = up;
        int_shift  = 5'(ki);
        prop_shift = 5'(kp);
        @(posedge clk);
        s      = m_res + (m_word & 12'hFFF);
        m_cry  = s >> 12;
        m_res  = s & 12'hFFF;
        m_acc  = mv(m_acc, ki, up);
        m_word = mv(m_acc, kp, up);
        @(negedge clk);
        compare_all(tag);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7331));
        m_acc = 24'h800000; m_word = 24'h800000; m_res = 0; m_cry = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state visible before first active update
        check("R1 band", int'(band_code), 32);
        check("R1 therm", int'(therm_code), 0);
        check("R1 bin", int'(bin_code), 0);
        // R2 R3 directed small steps
        step(1'b1, 4, 6, "R2 R3 up");
        step(1'b0, 4, 6, "R2 R3 down");
        step(1'b1, 15, 15, "R2 R3 seg");
        // R5: oversize shift acts as 23; R4 saturation at top
        step(1'b1, 30, 31, "R5 R4 top");
        check("R4 top band", int'(band_code), 63);
        step(1'b1, 23, 23, "R4 top hold");
        // dither carry meets binary max (R8 R9)
        for (int i = 0; i < 40; i++) step(1'b1, 0, 0, "R8 R9 cosat");
        check("R9 cosat bin", int'(bin_code), 7);
        // R4 saturation at zero
        for (int i = 0; i < 4; i++) step(1'b0, 31, 23, "R4 R5 bottom");
        check("R4 bottom band", int'(band_code), 0);
        check("R4 bottom therm", int'(therm_code), 0);
        // R7 walk thermometer field one step at a time from zero
        for (int i = 0; i < 9; i++) step(1'b1, 15, 0, "R7 walk");
        // randomized run
        for (int i = 0; i < 3000; i++)
            step(1'($urandom_range(0, 1)), int'($urandom_range(0, 24)),
                 int'($urandom_range(0, 26)), "R2 R3 R8 rand");
        // R1 mid-run reset
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_acc = 24'h800000; m_word = 24'h800000; m_res = 0; m_cry = 0;
        compare_all("R1 rerst");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule